// File: doc/BRIEF.md
# USB Transmit Packet Splitter

This block sits between a transmit endpoint FIFO and the logic that sends USB packets. It holds a 16-bit max-packet register with two fields: the payload size of one transaction and a multiplier. When a data packet has been loaded into the FIFO, the block receives the packet length. It then issues a series of transactions, each carrying a byte offset into the packet and a byte length. Each transaction is offered on a valid/ready handshake. The block does not touch FIFO data, tokens, CRC or line signalling.

The endpoint mode decides how the multiplier is used:

- **Bulk with splitting:** one loaded packet becomes up to 32 full-size packets.
- **High-bandwidth isochronous/interrupt at high speed:** one loaded packet becomes up to three transactions in one microframe, and the last one may be short.
- **Plain:** the multiplier bits are ignored and the packet goes out as one transaction.

A configuration or length that breaks the rules of the mode produces a one-cycle error pulse, and no transaction is issued. A flush input aborts the sequence in progress.

Top module: `usb_tx_splitter`

## Requirements
- R1: After reset, `req_valid`, `done` and `err` are low and the max-packet register reads zero.
- R2: A write stores `maxp_wdata`. Bits [10:0] are the payload size in bytes and bits [15:11] are the multiplier minus one. Every issued `req_len` is at most 1024.
- R3: Plain mode (`ep_mode`=0): bits [15:11] are ignored and the packet goes out as a single transaction with offset 0 and length `load_len`. The payload size must be 1 to 1024. A zero-length load in any accepted mode gives one transaction of length 0.
- R4: Bulk split mode (`ep_mode`=1) uses m = bits[15:11]+1, from 1 to 32. The packet is sent as `load_len`/payload transactions, each exactly one payload long, at offsets 0, payload, 2·payload, and so on.
- R5: Bulk split mode rejects the load in two cases. The first is a payload other than 8, 16, 32 or 64; 512 is allowed only when `high_speed`=1. The second is a `load_len` that is not a whole multiple of the payload.
- R6: High-bandwidth mode (`ep_mode`=2) with `high_speed`=1 reads bits [12:11] as 00→m=1, 01→m=2, 10→m=3. Bits [12:11]=11, or any of bits [15:13] set, is rejected. The packet is cut into full-payload pieces with a shorter last piece, and issuing stops once the last byte is covered, even if fewer than m transactions were used.
- R7: High-bandwidth mode with `high_speed`=0 ignores bits [15:11] and uses m=1.
- R8: A load is rejected in each of these cases: payload×m exceeds `FIFO_BYTES`, `load_len` exceeds payload×m, or `ep_mode`=3. A rejected load gives `err` high for one cycle, the cycle after the load, with no request.
- R9: `req_valid` rises the cycle after an accepted load. Offset and length hold steady until `req_ready` is seen. Each acknowledge advances the offset by the length just acknowledged.
- R10: `done` is high for exactly one cycle, the cycle after the acknowledge of the final transaction.
- R11: `flush` returns the sequencer to idle on the next edge with no `done`. The max-packet register keeps its value.
- R12: `load_valid` is ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Abort the current sequence |
| maxp_wr | input | 1 | Write strobe for the max-packet register |
| maxp_wdata | input | 16 | Max-packet register write value |
| ep_mode | input | 2 | 0 plain, 1 bulk split, 2 high-bandwidth, 3 reserved |
| high_speed | input | 1 | Bus runs at high speed |
| load_valid | input | 1 | A packet of `load_len` bytes is now in the FIFO |
| load_len | input | LEN_W | Loaded packet length in bytes |
| req_ready | input | 1 | Sender accepts the current transaction |
| req_valid | output | 1 | A transaction is offered |
| req_offset | output | LEN_W | Byte offset of the transaction in the packet |
| req_len | output | 11 | Byte length of the transaction |
| done | output | 1 | Final transaction acknowledged |
| err | output | 1 | Load rejected |

## Verification
The hardest situations to reach are those where the sequencer state interacts with later inputs. Examples are a flush while a request is stalled, or a second load arriving mid-sequence. The bench reaches them by holding `req_ready` low for a stretch, then pulsing `flush` or `load_valid` while the request is pending. At other times it drives `req_ready` in an irregular pattern, so that stalls fall on first, middle and final transactions. A reference model with its own transaction queue predicts every output on every cycle.

// File: rtl/usb_tx_split_pkg.sv
package usb_tx_split_pkg;
  localparam int PAY_W       = 11;
  localparam int MULT_W      = 5;
  localparam int MAX_PAYLOAD = 1024;

  typedef enum logic [1:0] {
    EP_PLAIN      = 2'd0,
    EP_BULK_SPLIT = 2'd1,
    EP_HIGH_BW    = 2'd2,
    EP_RESERVED   = 2'd3
  } ep_mode_e;

  typedef struct packed {
    logic [MULT_W-1:0] mult_m1;
    logic [PAY_W-1:0]  payload;
  } maxp_t;
endpackage

// File: rtl/usb_tx_maxp_reg.sv
module usb_tx_maxp_reg
  import usb_tx_split_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  maxp_t wdata,
  output maxp_t cfg_q
);
  maxp_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/usb_tx_split_check.sv
module usb_tx_split_check
  import usb_tx_split_pkg::*;
#(
  parameter int FIFO_BYTES = 4096,
  parameter int LEN_W      = 13
) (
  input  ep_mode_e         mode,
  input  logic             high_speed,
  input  maxp_t            cfg,
  input  logic [LEN_W-1:0] len,
  output logic             reject
);
  localparam int SPAN_W = PAY_W + MULT_W + 1;
  localparam int EXT_W  = (LEN_W > SPAN_W) ? LEN_W : SPAN_W;

  logic [MULT_W:0]    mult;
  logic [SPAN_W-1:0]  span;
  logic [EXT_W-1:0]   len_x;
  logic [EXT_W-1:0]   span_x;
  logic               size_ok;
  logic               pow_ok;
  logic               bad_cfg;
  logic               bad_len;
  logic               bad_fifo;
  logic               bad_big;

  assign size_ok = (cfg.payload != '0) && (cfg.payload <= PAY_W'(MAX_PAYLOAD));
  assign pow_ok  = (cfg.payload == PAY_W'(8))  || (cfg.payload == PAY_W'(16)) ||
                   (cfg.payload == PAY_W'(32)) || (cfg.payload == PAY_W'(64)) ||
                   ((cfg.payload == PAY_W'(512)) && high_speed);

  always_comb begin
    mult    = (MULT_W+1)'(1);
    bad_cfg = 1'b0;
    bad_len = 1'b0;
    len_x   = EXT_W'(len);
    unique case (mode)
      EP_PLAIN: begin
        bad_cfg = !size_ok;
      end
      EP_BULK_SPLIT: begin
        mult    = {1'b0, cfg.mult_m1} + (MULT_W+1)'(1);
        bad_cfg = !pow_ok;
        bad_len = (len_x[PAY_W-1:0] & (cfg.payload - PAY_W'(1))) != '0;
      end
      EP_HIGH_BW: begin
        bad_cfg = !size_ok;
        if (high_speed) begin
          mult = (MULT_W+1)'(cfg.mult_m1[1:0]) + (MULT_W+1)'(1);
          if ((cfg.mult_m1[MULT_W-1:2] != '0) || (cfg.mult_m1[1:0] == 2'b11))
            bad_cfg = 1'b1;
        end
      end
      EP_RESERVED: begin
        bad_cfg = 1'b1;
      end
      default: bad_cfg = 1'b1;
    endcase
  end

  assign span     = SPAN_W'(cfg.payload) * SPAN_W'(mult);
  assign span_x   = EXT_W'(span);
  assign bad_fifo = span_x > EXT_W'(FIFO_BYTES);
  assign bad_big  = len_x > span_x;
  assign reject   = bad_cfg | bad_len | bad_fifo | bad_big;
endmodule

// File: rtl/usb_tx_split_seq.sv
module usb_tx_split_seq
  import usb_tx_split_pkg::*;
#(
  parameter int LEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             start,
  input  logic             reject,
  input  logic [LEN_W-1:0] len,
  input  logic [PAY_W-1:0] payload,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [LEN_W-1:0] req_offset,
  output logic [PAY_W-1:0] req_len,
  output logic             done,
  output logic             err
);
  localparam int CMP_W = (LEN_W > PAY_W) ? LEN_W : PAY_W;

  typedef enum logic {SQ_IDLE, SQ_BUSY} sq_state_e;

  sq_state_e        state_q, state_d;
  logic [LEN_W-1:0] off_q, off_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [PAY_W-1:0] pay_q, pay_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic             data_en;
  logic [CMP_W-1:0] rem_w;
  logic [CMP_W-1:0] pay_w;
  logic             take_full;

  assign rem_w     = CMP_W'(rem_q);
  assign pay_w     = CMP_W'(pay_q);
  assign take_full = rem_w > pay_w;
  assign req_len   = take_full ? pay_q : PAY_W'(rem_q);

  always_comb begin
    state_d = state_q;
    off_d   = off_q;
    rem_d   = rem_q;
    pay_d   = pay_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    if (flush) begin
      state_d = SQ_IDLE;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          if (start) begin
            if (reject) begin
              err_d = 1'b1;
            end else begin
              state_d = SQ_BUSY;
              off_d   = '0;
              rem_d   = len;
              pay_d   = payload;
            end
          end
        end
        SQ_BUSY: begin
          if (req_ready) begin
            off_d = off_q + LEN_W'(req_len);
            rem_d = rem_q - LEN_W'(req_len);
            if (!take_full) begin
              state_d = SQ_IDLE;
              done_d  = 1'b1;
            end
          end
        end
        default: state_d = SQ_IDLE;
      endcase
    end
  end

  assign data_en = (state_q == SQ_IDLE) || req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      rem_q <= '0;
      pay_q <= '0;
    end else if (data_en) begin
      off_q <= off_d;
      rem_q <= rem_d;
      pay_q <= pay_d;
    end
  end

  assign req_valid  = (state_q == SQ_BUSY);
  assign req_offset = off_q;
  assign done       = done_q;
  assign err        = err_q;
endmodule

// File: rtl/usb_tx_splitter.sv
module usb_tx_splitter
  import usb_tx_split_pkg::*;
#(
  parameter int FIFO_BYTES = 4096,
  localparam int LEN_W     = $clog2(FIFO_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             maxp_wr,
  input  logic [15:0]      maxp_wdata,
  input  logic [1:0]       ep_mode,
  input  logic             high_speed,
  input  logic             load_valid,
  input  logic [LEN_W-1:0] load_len,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [LEN_W-1:0] req_offset,
  output logic [10:0]      req_len,
  output logic             done,
  output logic             err
);
  maxp_t cfg_q;
  logic  reject;

  usb_tx_maxp_reg u_maxp (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (maxp_wr),
    .wdata (maxp_t'(maxp_wdata)),
    .cfg_q (cfg_q)
  );

  usb_tx_split_check #(
    .FIFO_BYTES (FIFO_BYTES),
    .LEN_W      (LEN_W)
  ) u_check (
    .mode       (ep_mode_e'(ep_mode)),
    .high_speed (high_speed),
    .cfg        (cfg_q),
    .len        (load_len),
    .reject     (reject)
  );

  usb_tx_split_seq #(
    .LEN_W (LEN_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .start      (load_valid),
    .reject     (reject),
    .len        (load_len),
    .payload    (cfg_q.payload),
    .req_ready  (req_ready),
    .req_valid  (req_valid),
    .req_offset (req_offset),
    .req_len    (req_len),
    .done       (done),
    .err        (err)
  );
endmodule

// File: rtl/usb_tx_splitter_chk.sv
module usb_tx_splitter_chk #(
  parameter int LEN_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             req_ready,
  input logic             req_valid,
  input logic [LEN_W-1:0] req_offset,
  input logic [10:0]      req_len,
  input logic             done,
  input logic             err
);
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len <= 11'd1024)); // R2

  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!req_valid && !done)); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !flush) |=>
      (req_valid && $stable(req_offset) && $stable(req_len))); // R9

  AST_OFFSET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !flush) |=>
      (!req_valid || (req_offset == LEN_W'($past(req_offset) + LEN_W'($past(req_len)))))); // R9

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(req_valid && req_ready)); // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_FLUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!req_valid && !done && !err)); // R11
endmodule

bind usb_tx_splitter usb_tx_splitter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .req_ready  (req_ready),
  .req_valid  (req_valid),
  .req_offset (req_offset),
  .req_len    (req_len),
  .done       (done),
  .err        (err)
);

// File: tb/usb_tx_splitter_tb_top.sv
`timescale 1ns/1ps
module usb_tx_splitter_tb_top;
  localparam int FIFO_BYTES = 4096;
  localparam int LEN_W      = $clog2(FIFO_BYTES + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             flush;
  logic             maxp_wr;
  logic [15:0]      maxp_wdata;
  logic [1:0]       ep_mode;
  logic             high_speed;
  logic             load_valid;
  logic [LEN_W-1:0] load_len;
  logic             req_ready;
  logic             req_valid;
  logic [LEN_W-1:0] req_offset;
  logic [10:0]      req_len;
  logic             done;
  logic             err;

  always #4 clk = ~clk;

  usb_tx_splitter #(.FIFO_BYTES(FIFO_BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .maxp_wr(maxp_wr),
    .maxp_wdata(maxp_wdata), .ep_mode(ep_mode), .high_speed(high_speed),
    .load_valid(load_valid), .load_len(load_len), .req_ready(req_ready),
    .req_valid(req_valid), .req_offset(req_offset), .req_len(req_len),
    .done(done), .err(err)
  );

  int    total = 0;
  int    bad   = 0;
  int    cyc   = 0;
  int    rdy_mode = 0;
  string cur_req = "R1";

  // reference model state
  int    m_off[$];
  int    m_len[$];
  bit    m_busy, m_done, m_err;
  int    m_reg;

  function automatic bit m_plan(int md, bit hs, int rg, int len);
    int  p = rg & 16'h07ff;
    int  mc = (rg >> 11) & 31;
    int  m = 1;
    bit  rej = 0;
    int  off;
    case (md)
      0: rej = (p == 0) || (p > 1024);
      1: begin
        m = mc + 1;
        rej = !((p == 8) || (p == 16) || (p == 32) || (p == 64) || (p == 512 && hs));
        if (!rej) rej = (len % p) != 0;
      end
      2: begin
        rej = (p == 0) || (p > 1024);
        if (hs) begin
          if (mc > 2) rej = 1;
          m = mc + 1;
        end
      end
      default: rej = 1;
    endcase
    if (!rej) rej = (p * m > FIFO_BYTES) || (len > p * m);
    if (rej) return 1;
    if (len == 0) begin
      m_off.push_back(0);
      m_len.push_back(0);
    end else begin
      off = 0;
      while (off < len) begin
        m_off.push_back(off);
        m_len.push_back((len - off > p) ? p : len - off);
        off += p;
      end
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_err = 0; m_reg = 0;
      m_off.delete(); m_len.delete();
    end else begin
      if (flush) begin
        m_busy = 0; m_done = 0; m_err = 0;
        m_off.delete(); m_len.delete();
      end else begin
        m_done = 0; m_err = 0;
        if (m_busy) begin
          if (req_ready) begin
            void'(m_off.pop_front());
            void'(m_len.pop_front());
            if (m_off.size() == 0) begin
              m_busy = 0;
              m_done = 1;
            end
          end
        end else if (load_valid) begin
          if (m_plan(int'(ep_mode), high_speed, m_reg, int'(load_len))) m_err = 1;
          else m_busy = 1;
        end
      end
      if (maxp_wr) m_reg = int'(maxp_wdata);
    end
  end

  // compare every cycle, drive ready, watchdog
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      bit ok;
      ok = (req_valid == m_busy) && (done == m_done) && (err == m_err);
      if (ok && m_busy)
        ok = (int'(req_offset) == m_off[0]) && (int'(req_len) == m_len[0]);
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL %s cyc=%0d actual v=%0b off=%0d len=%0d done=%0b err=%0b expected v=%0b off=%0d len=%0d done=%0b err=%0b",
                 cur_req, cyc, req_valid, req_offset, req_len, done, err,
                 m_busy, m_busy ? m_off[0] : 0, m_busy ? m_len[0] : 0, m_done, m_err);
      end
    end
    case (rdy_mode)
      0: req_ready = 1'b1;
      1: req_ready = (cyc % 3) != 0;
      default: req_ready = 1'b0;
    endcase
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic write_maxp(input int v);
    @(negedge clk);
    maxp_wr = 1'b1; maxp_wdata = 16'(v);
    @(negedge clk);
    maxp_wr = 1'b0;
  endtask

  task automatic pulse_load(input int len);
    @(negedge clk);
    load_valid = 1'b1; load_len = LEN_W'(len);
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic run_pkt(input int len);
    pulse_load(len);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; flush = 1'b0; maxp_wr = 1'b0; maxp_wdata = '0;
    ep_mode = 2'd0; high_speed = 1'b1; load_valid = 1'b0; load_len = '0;
    req_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    total++;
    if (req_valid || done || err) begin
      bad++;
      $display("FAIL R1 actual v=%0b done=%0b err=%0b expected 0 0 0", req_valid, done, err);
    end
    run_pkt(0);

    cur_req = "R3";
    write_maxp(16'hF800 | 64);
    run_pkt(50); run_pkt(64); run_pkt(0);
    cur_req = "R2";
    write_maxp((5 << 11) | 33);
    run_pkt(33);
    cur_req = "R10";
    rdy_mode = 1;
    run_pkt(20); run_pkt(33);

    cur_req = "R4";
    ep_mode = 2'd1;
    write_maxp((3 << 11) | 64);  run_pkt(256); run_pkt(128);
    write_maxp((31 << 11) | 8);  run_pkt(256);
    write_maxp((1 << 11) | 512); run_pkt(1024); run_pkt(0);

    cur_req = "R5";
    write_maxp((3 << 11) | 64);  run_pkt(100);
    write_maxp((3 << 11) | 100); run_pkt(200);
    high_speed = 1'b0;
    write_maxp((1 << 11) | 512); run_pkt(512);
    high_speed = 1'b1;

    cur_req = "R8";
    write_maxp((15 << 11) | 512); run_pkt(512);
    write_maxp((31 << 11) | 8);   run_pkt(264);
    ep_mode = 2'd0;
    write_maxp(64); run_pkt(65);
    ep_mode = 2'd3; run_pkt(10);

    cur_req = "R6";
    ep_mode = 2'd2;
    write_maxp((1 << 11) | 1024); run_pkt(1500);
    write_maxp((2 << 11) | 1024); run_pkt(3072); run_pkt(1100);
    write_maxp((3 << 11) | 1024); run_pkt(100);
    write_maxp((4 << 11) | 100);  run_pkt(100);

    cur_req = "R7";
    high_speed = 1'b0;
    write_maxp((2 << 11) | 200); run_pkt(200); run_pkt(300);
    high_speed = 1'b1;

    cur_req = "R9";
    rdy_mode = 1;
    write_maxp((2 << 11) | 700); run_pkt(2000);

    cur_req = "R11";
    ep_mode = 2'd1;
    write_maxp((3 << 11) | 64);
    rdy_mode = 2;
    pulse_load(256);
    repeat (4) @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    rdy_mode = 0;
    repeat (3) @(negedge clk);
    run_pkt(128);

    cur_req = "R12";
    rdy_mode = 2;
    pulse_load(256);
    repeat (2) @(negedge clk);
    pulse_load(64);
    repeat (2) @(negedge clk);
    rdy_mode = 1;
    while (m_busy) @(negedge clk);
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule